// File: doc/BRIEF.md
# Serial ADC Sample Capture Controller

This block runs a serial analog-to-digital converter and stores its 16-bit results in an external pseudo-static RAM buffer. For each sample it does four things in order. It pulses the converter's start line for one clock. It waits a fixed conversion time. It clocks the 16-bit result in serially, most significant bit first. It then holds a write strobe on the RAM for a fixed number of clocks, so the slow memory has time to finish. The conversion wait, the serial readout and the memory write all fit inside one sample period, so no sample is dropped at the full rate.

Software sets the sample period, the number of samples and the start source, and then arms the block. In immediate mode, capture starts as soon as the block is armed. In trigger mode, the block waits for a rising edge on an external trigger input. After that, samples follow one another at the programmed period. Capture stops when the programmed number of samples has been written to the buffer. The block then shows a done flag. The flag stays set until the block is armed again.

All times are counted in clocks. With the default parameters and a 100 MHz reference clock:

- the minimum sample period is 100 clocks (1 µs);
- the conversion wait is 56 clocks;
- each serial bit takes 2 clocks;
- each RAM write strobe lasts 7 clocks.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset, `adc_convst_o`=0, `adc_sclk_o`=0, `ram_we_n_o`=1, `busy_o`=0, `done_o`=0 and `ram_addr_o`=0.
- R2: In immediate mode (`ext_mode_i`=0), an `arm_i` pulse starts capture. `adc_convst_o` goes high for exactly one clock per sample. Successive start pulses are exactly `period_i` clocks apart.
- R3: A `period_i` value below SAMPLE_CYC (default 100) is treated as SAMPLE_CYC, so start pulses are then SAMPLE_CYC clocks apart.
- R4: The first rising edge of `adc_sclk_o` in a sample comes CONV_CYC+1 clocks (default 57) after `adc_convst_o` rises. Each sample then has exactly 16 `adc_sclk_o` pulses, each one clock high and one clock low.
- R5: `adc_sdata_i` is sampled on the clock edge that drives `adc_sclk_o` high. The first bit sampled becomes bit 15 of the stored word, and later bits fill the lower positions in order.
- R6: After the 16th bit, `ram_we_n_o` is low for exactly WR_CYC clocks (default 7). During that time `ram_wdata_o` and `ram_addr_o` hold steady and `adc_sclk_o` stays low.
- R7: The first write after an accepted arm goes to address 0. The address rises by one after each write strobe ends.
- R8: Exactly `count_i` samples are converted and written. When the last write strobe ends, `done_o` goes high and `busy_o` goes low.
- R9: An accepted arm clears `done_o`. An arm with `count_i`=0 sets `done_o` and causes no conversion.
- R10: In trigger mode (`ext_mode_i`=1), an armed block holds `busy_o` high and starts no conversion until `trig_i` rises. The first start pulse then follows.
- R11: A `trig_i` edge or an `arm_i` pulse that arrives while a capture is running has no effect on the number, spacing or addresses of samples. A `trig_i` edge while the block is idle starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| arm_i | input | 1 | Arm pulse; accepted only while the block is idle |
| ext_mode_i | input | 1 | 1 = wait for a trigger edge, 0 = start at once |
| trig_i | input | 1 | External trigger; its rising edge starts capture |
| period_i | input | PER_W | Sample period in clocks, with a minimum of SAMPLE_CYC |
| count_i | input | ADDR_W+1 | Number of samples to capture |
| adc_convst_o | output | 1 | Conversion start pulse to the converter |
| adc_sclk_o | output | 1 | Serial bit clock to the converter |
| adc_sdata_i | input | 1 | Serial data from the converter |
| ram_addr_o | output | ADDR_W | Buffer write address |
| ram_wdata_o | output | DATA_W | Buffer write data |
| ram_we_n_o | output | 1 | Active-low buffer write strobe |
| busy_o | output | 1 | Armed or capturing |
| done_o | output | 1 | Programmed sample count has been stored |

## Verification
Each faulty internal state shows up at the ports within one sample period, and most within a few clocks:

- A wrong conversion-wait or strobe timer shows as a shifted first serial clock edge or a strobe of the wrong length in that same sample.
- A bad shift order or a wrong sampling edge shows as a wrong buffer word at the first write.
- A faulty period counter shows as a gap of the wrong length between the first two start pulses.
- Faults in the address counter or the sample counters show as a repeated or skipped address, or as a wrong number of start pulses before `done_o` rises.

Stray trigger or arm edges are applied during a run and while idle. The bench then checks the start-pulse count, the spacing and the addresses.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_RUN   = 2'd2
    } pacer_state_e;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_CONV  = 2'd1,
        E_SHIFT = 2'd2,
        E_WRITE = 2'd3
    } engine_state_e;

endpackage

// File: rtl/adc_cap_pacer.sv
module adc_cap_pacer
    import adc_cap_pkg::*;
#(
    parameter int PER_W   = 16,
    parameter int CNT_W   = 11,
    parameter int PER_MIN = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             ext_mode_i,
    input  logic             trig_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_done_i,
    output logic             start_o,
    output logic             clr_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [PER_W-1:0] PER_MIN_V = PER_W'(PER_MIN);

    typedef struct packed {
        pacer_state_e     state;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] pc;
        logic [CNT_W-1:0] issue;
        logic [CNT_W-1:0] left;
        logic             done;
        logic             trig_prev;
    } pacer_t;

    pacer_t q, d;
    logic   trig_rise;
    logic [PER_W-1:0] per_eff;

    always_comb begin
        d         = q;
        start_o   = 1'b0;
        clr_o     = 1'b0;
        trig_rise = trig_i && !q.trig_prev;
        per_eff   = (period_i < PER_MIN_V) ? PER_MIN_V : period_i;
        d.trig_prev = trig_i;

        unique case (q.state)
            S_IDLE: begin
                if (arm_i) begin
                    clr_o  = 1'b1;
                    d.done = 1'b0;
                    if (count_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.issue = count_i;
                        d.left  = count_i;
                        d.per   = per_eff;
                        d.pc    = '0;
                        d.state = ext_mode_i ? S_ARMED : S_RUN;
                    end
                end
            end
            S_ARMED: begin
                if (trig_rise) begin
                    d.state = S_RUN;
                    d.pc    = '0;
                end
            end
            S_RUN: begin
                if (q.pc == '0) begin
                    d.pc = q.per - 1'b1;
                    if (q.issue != '0) begin
                        start_o = 1'b1;
                        d.issue = q.issue - 1'b1;
                    end
                end else begin
                    d.pc = q.pc - 1'b1;
                end
                if (wr_done_i) begin
                    d.left = q.left - 1'b1;
                    if (q.left == CNT_W'(1)) begin
                        d.state = S_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, per: '0, pc: '0, issue: '0, left: '0,
                   done: 1'b0, trig_prev: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.state != S_IDLE);
    assign done_o = q.done;

    // R8: done is only shown once the run has ended
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.state == S_IDLE));

    // R8: never more samples issued than still owed to the buffer
    p_issue_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_RUN) |-> (q.issue <= q.left));

    // R11: a running capture never falls back to waiting for a trigger
    p_no_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_RUN) |=> (q.state != S_ARMED));

    // R9: an accepted arm clears the done flag unless the count is zero
    p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && arm_i && count_i != '0) |=> !q.done);

endmodule

// File: rtl/adc_cap_engine.sv
module adc_cap_engine
    import adc_cap_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CONV_CYC = 56,
    parameter int WR_CYC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sdata_i,
    output logic              convst_o,
    output logic              sclk_o,
    output logic              we_n_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              wr_done_o
);

    localparam int TMR_MAX = (CONV_CYC > WR_CYC) ? CONV_CYC : WR_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    typedef struct packed {
        engine_state_e     state;
        logic [TMR_W-1:0]  tmr;
        logic [BIT_W-1:0]  bitn;
        logic              sclk;
        logic              convst;
        logic              we_n;
        logic [DATA_W-1:0] shreg;
    } engine_t;

    engine_t q, d;

    always_comb begin
        d         = q;
        d.convst  = 1'b0;
        wr_done_o = 1'b0;

        unique case (q.state)
            E_IDLE: begin
                if (start_i) begin
                    d.state  = E_CONV;
                    d.convst = 1'b1;
                    d.tmr    = TMR_W'(CONV_CYC - 1);
                end
            end
            E_CONV: begin
                if (q.tmr == '0) begin
                    d.state = E_SHIFT;
                    d.bitn  = '0;
                    d.sclk  = 1'b0;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            E_SHIFT: begin
                if (!q.sclk) begin
                    d.sclk  = 1'b1;
                    d.shreg = {q.shreg[DATA_W-2:0], sdata_i};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bitn == BIT_W'(DATA_W - 1)) begin
                        d.state = E_WRITE;
                        d.we_n  = 1'b0;
                        d.tmr   = TMR_W'(WR_CYC - 1);
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                    end
                end
            end
            E_WRITE: begin
                if (q.tmr == '0) begin
                    d.we_n    = 1'b1;
                    d.state   = E_IDLE;
                    wr_done_o = 1'b1;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            default: d.state = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: E_IDLE, tmr: '0, bitn: '0, sclk: 1'b0,
                   convst: 1'b0, we_n: 1'b1, shreg: '0};
        end else begin
            q <= d;
        end
    end

    assign convst_o = q.convst;
    assign sclk_o   = q.sclk;
    assign we_n_o   = q.we_n;
    assign wdata_o  = q.shreg;

    // R3: the pacer never requests a sample before the previous one is stored
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.state == E_IDLE));

    // R2: the start pulse is a single clock wide
    p_convst_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.convst |=> !q.convst);

    // R6: no serial clocking during a buffer write
    p_we_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> (!q.sclk && !q.convst));

    // R6: write data holds for the whole strobe
    p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.we_n && !$past(q.we_n)) |-> $stable(q.shreg));

endmodule

// File: rtl/adc_cap_bufaddr.sv
module adc_cap_bufaddr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr_i) begin
            addr_d = '0;
        end else if (inc_i) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

    // R7: each completed write moves the buffer pointer by exactly one
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 10,
    parameter int PER_W      = 16,
    parameter int SAMPLE_CYC = 100,
    parameter int CONV_CYC   = 56,
    parameter int WR_CYC     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              ext_mode_i,
    input  logic              trig_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [ADDR_W:0]   count_i,
    output logic              adc_convst_o,
    output logic              adc_sclk_o,
    input  logic              adc_sdata_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_we_n_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W      = ADDR_W + 1;
    localparam int ENGINE_CYC = CONV_CYC + 2 * DATA_W + WR_CYC + 1;
    localparam int PER_MIN    = (SAMPLE_CYC > ENGINE_CYC) ? SAMPLE_CYC : ENGINE_CYC;

    logic start, clr, wr_done;

    adc_cap_pacer #(
        .PER_W  (PER_W),
        .CNT_W  (CNT_W),
        .PER_MIN(PER_MIN)
    ) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .ext_mode_i(ext_mode_i),
        .trig_i    (trig_i),
        .period_i  (period_i),
        .count_i   (count_i),
        .wr_done_i (wr_done),
        .start_o   (start),
        .clr_o     (clr),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    adc_cap_engine #(
        .DATA_W  (DATA_W),
        .CONV_CYC(CONV_CYC),
        .WR_CYC  (WR_CYC)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .sdata_i  (adc_sdata_i),
        .convst_o (adc_convst_o),
        .sclk_o   (adc_sclk_o),
        .we_n_o   (ram_we_n_o),
        .wdata_o  (ram_wdata_o),
        .wr_done_o(wr_done)
    );

    adc_cap_bufaddr #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (wr_done),
        .addr_o(ram_addr_o)
    );

endmodule

// File: tb/tb_adc_capture_ctrl.sv
module tb_adc_capture_ctrl;

    localparam int DW = 16, AW = 10, PW = 16;
    localparam int CONV = 56, WR = 7, SMIN = 100;
    localparam int LOGN = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm = 1'b0, ext_mode = 1'b0, trig = 1'b0;
    logic [PW-1:0] period = '0;
    logic [AW:0]   count = '0;
    logic convst, sclk, sdata, we_n, busy, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;

    adc_capture_ctrl #(.DATA_W(DW), .ADDR_W(AW), .PER_W(PW),
        .SAMPLE_CYC(SMIN), .CONV_CYC(CONV), .WR_CYC(WR)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .ext_mode_i(ext_mode),
        .trig_i(trig), .period_i(period), .count_i(count),
        .adc_convst_o(convst), .adc_sclk_o(sclk), .adc_sdata_i(sdata),
        .ram_addr_o(addr), .ram_wdata_o(wdata), .ram_we_n_o(we_n),
        .busy_o(busy), .done_o(done));

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] adc_word(int k);
        logic [7:0] b = 8'(k * 37 + 5);
        return {b, ~b} ^ 16'hC3A5;
    endfunction

    // converter model: new bit presented after each sampled rising sclk
    int adc_k = 0, bitidx = 16;
    logic [DW-1:0] cur_word = '0;
    logic m_sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (convst) begin
            cur_word = adc_word(adc_k);
            adc_k++;
            bitidx = 0;
        end else if (sclk && !m_sclk_prev) begin
            bitidx++;
        end
        m_sclk_prev = sclk;
        sdata = (bitidx < 16) ? cur_word[15 - bitidx] : 1'b0;
    end
    initial sdata = 1'b0;

    // event log
    int nconv, nwr, wide_err, unstable;
    int conv_t [LOGN];
    int sclk_t [LOGN];
    int nsclk  [LOGN];
    logic [DW-1:0] exp_w [LOGN];
    logic [AW-1:0] wr_addr [LOGN];
    logic [DW-1:0] wr_data [LOGN];
    int wr_len [LOGN];
    logic p_cv = 1'b0, p_sk = 1'b0, p_we = 1'b1;

    task automatic clear_log();
        nconv = 0; nwr = 0; wide_err = 0; unstable = 0;
        for (int i = 0; i < LOGN; i++) begin
            nsclk[i] = 0; wr_len[i] = 0; sclk_t[i] = -1;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (convst && p_cv) wide_err++;
        if (convst && !p_cv) begin
            if (nconv < LOGN) begin
                conv_t[nconv] = cyc;
                exp_w[nconv] = adc_word(adc_k - 1);
            end
            nconv++;
        end
        if (sclk && !p_sk && nconv > 0 && nconv <= LOGN) begin
            if (nsclk[nconv-1] == 0) sclk_t[nconv-1] = cyc;
            nsclk[nconv-1]++;
        end
        if (!we_n && p_we && nwr < LOGN) begin
            wr_addr[nwr] = addr; wr_data[nwr] = wdata; wr_len[nwr] = 1;
            nwr++;
        end else if (!we_n && nwr > 0 && nwr <= LOGN) begin
            wr_len[nwr-1]++;
            if (addr != wr_addr[nwr-1] || wdata != wr_data[nwr-1] || sclk)
                unstable++;
        end
        p_cv = convst; p_sk = sclk; p_we = we_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wait_done(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    // common checks for a finished run of n samples at spacing sp
    task automatic check_run(input int n, input int sp, input string tag);
        check(nconv == n, {tag, " R8 conversions"}, nconv, n);
        check(nwr == n, {tag, " R8 writes"}, nwr, n);
        check(wide_err == 0, {tag, " R2 convst width"}, wide_err, 0);
        check(unstable == 0, {tag, " R6 strobe stability"}, unstable, 0);
        check(done && !busy, {tag, " R8 done/busy"}, {done, busy}, 2);
        for (int i = 0; i < n && i < LOGN; i++) begin
            if (i > 0)
                check(conv_t[i] - conv_t[i-1] == sp, {tag, " R2 spacing"},
                      conv_t[i] - conv_t[i-1], sp);
            check(sclk_t[i] - conv_t[i] == CONV + 1, {tag, " R4 conv wait"},
                  sclk_t[i] - conv_t[i], CONV + 1);
            check(nsclk[i] == 16, {tag, " R4 bit count"}, nsclk[i], 16);
            check(wr_data[i] == exp_w[i], {tag, " R5 word"}, wr_data[i], exp_w[i]);
            check(wr_len[i] == WR, {tag, " R6 strobe length"}, wr_len[i], WR);
            check(wr_addr[i] == AW'(i), {tag, " R7 address"}, wr_addr[i], i);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!convst && !sclk && we_n, "R1 outputs", {convst, sclk, we_n}, 1);
        check(!busy && !done, "R1 status", {busy, done}, 0);
        check(addr == '0, "R1 address", addr, 0);
    endtask

    task automatic t_periodic();
        clear_log();
        ext_mode = 1'b0; period = 16'd120; count = 11'd4;
        pulse_arm();
        check(busy && !done, "R2 busy after arm", {busy, done}, 2);
        wait_done(1200);
        check_run(4, 120, "periodic");
    endtask

    task automatic t_min_period();
        clear_log();
        period = 16'd10; count = 11'd3;
        pulse_arm();
        wait_done(1000);
        check_run(3, SMIN, "R3 min period");
    endtask

    task automatic t_rearm();
        clear_log();
        period = 16'd105; count = 11'd2;
        pulse_arm();
        check(!done, "R9 done cleared by arm", done, 0);
        wait_done(800);
        check_run(2, 105, "R9 rearm");
    endtask

    task automatic t_count_zero();
        clear_log();
        count = '0;
        pulse_arm();
        repeat (300) @(negedge clk);
        check(done && !busy, "R9 zero count done", {done, busy}, 2);
        check(nconv == 0, "R9 zero count no conversion", nconv, 0);
    endtask

    task automatic t_ext_trigger();
        clear_log();
        ext_mode = 1'b1; period = 16'd100; count = 11'd3;
        pulse_arm();
        repeat (300) @(negedge clk);
        check(busy && !done, "R10 waiting busy", {busy, done}, 2);
        check(nconv == 0, "R10 no conversion before trigger", nconv, 0);
        pulse_trig();
        wait_done(800);
        check_run(3, 100, "R10 triggered");
    endtask

    task automatic t_ignore();
        clear_log();
        ext_mode = 1'b1; period = 16'd110; count = 11'd4;
        pulse_arm();
        pulse_trig();
        for (int i = 0; i < 400 && nconv < 2; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse_trig();
        repeat (30) @(negedge clk);
        pulse_arm();
        pulse_trig();
        wait_done(1200);
        check_run(4, 110, "R11 stray edges");
        clear_log();
        ext_mode = 1'b0;
        pulse_trig();
        repeat (300) @(negedge clk);
        check(nconv == 0, "R11 idle trigger", nconv, 0);
        check(done && !busy, "R11 idle status kept", {done, busy}, 2);
    endtask

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_min_period();
        t_rearm();
        t_count_zero();
        t_ext_trigger();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule